// File: doc/BRIEF.md
# Cascaded 16-bit Compare Timer

This block builds a 16-bit interval timer out of two 8-bit segments. The low segment counts one step on every cycle where the count enable is high. The high segment steps only when the low segment rolls over from its all-ones value. Each segment compares its count against its own 8-bit compare value. A match in one segment never clears that segment by itself. The timer period closes only when both segments match on the same counting step. On that step both counts return to zero, a one-cycle period interrupt fires and, if enabled, the timer output level flips.

The low-segment match is reported every time it occurs, including the steps that fall inside a longer 16-bit period. It drives a match pulse and a separate low-half interrupt. With compare values `{hi, lo}`, the period is `{hi, lo} + 1` counting steps. The timer output therefore makes a square wave whose half-period is set by the two compare values.

Top module: `casc_cmp_timer`

## Requirements
- R1: On a cycle with `run` and `tick_en` high and the low count equal to `cmp_lo`, `lo_match` is high for exactly the following cycle. The low count still advances by one, unless R3 applies.
- R2: The high count changes only on a counting step where the low count is 0xFF, or when it is cleared by R3 or R8.
- R3: When both segments match on the same counting step, both counts become zero on that clock edge.
- R4: `period_irq` is high for the single cycle that follows each step on which both segments matched, and is low otherwise.
- R5: On a coincident match with `toggle_en` high, `tmr_out` inverts. With `toggle_en` low, and on every other cycle, `tmr_out` keeps its level.
- R6: With `cmp_hi` = 0x04 and `cmp_lo` = 0x80, counting from zero, `period_irq` follows step 0x0480, so the period is 0x0481 steps. `lo_match` follows steps 0x0080, 0x0180, 0x0280, 0x0380 and 0x0480, and no others.
- R7: `lo_irq` is high on exactly the cycles where `lo_match` is high.
- R8: While `run` is low, both counts are forced to zero and `lo_match`, `lo_irq` and `period_irq` stay low. After `run` returns high, counting restarts from zero.
- R9: Synchronous reset (`rst` high) drives both counts, `tmr_out` and all pulse outputs to 0.
- R10: On a cycle with `tick_en` low, neither count changes and no pulse output is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tick_en | input | 1 | Prescaled count enable, one counting step per high cycle |
| run | input | 1 | Timer run control; low holds the counts at zero |
| cmp_lo | input | 8 | Compare value of the low segment |
| cmp_hi | input | 8 | Compare value of the high segment |
| toggle_en | input | 1 | Lets a coincident match invert `tmr_out` |
| lo_match | output | 1 | Low-segment match pulse |
| lo_irq | output | 1 | Low-half interrupt pulse |
| period_irq | output | 1 | Full-period interrupt pulse |
| tmr_out | output | 1 | Timer output level |

## Verification
All pulse outputs and `tmr_out` are registered. Each one responds to the counting step whose inputs are present at a clock edge, and shows the result in the cycle that follows that edge. The bench drives inputs on the falling edge and lets exactly one rising edge pass. It then samples on the next falling edge and compares against a reference that has been advanced by that same single step. Count state is never read directly. It is inferred from how many steps separate the pulses, for example the first period interrupt after `run` is restored, or after a stretch with `tick_en` low.

// File: rtl/casc_tmr_pkg.sv
package casc_tmr_pkg;

    localparam int unsigned TMR_SEG_W = 8;
    localparam int unsigned TMR_N_SEG = 2;

    typedef struct packed {
        logic lo_hit;
        logic coinc;
    } tmr_evt_t;

    function automatic tmr_evt_t tmr_make_evt(input logic lo_hit, input logic all_hit);
        tmr_evt_t e;
        e.lo_hit = lo_hit;
        e.coinc  = all_hit;
        return e;
    endfunction

endpackage

// File: rtl/tmr_seg.sv
module tmr_seg #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         run,
    input  logic         step,
    input  logic         clear,
    input  logic [W-1:0] cmp,
    output logic [W-1:0] cnt,
    output logic         eq
);

    always_ff @(posedge clk) begin
        if (rst || clear || !run) begin
            cnt <= '0;
        end else if (step) begin
            cnt <= cnt + W'(1);
        end
    end

    assign eq = (cnt == cmp);

    AST_SEG_HOLD: assert property (@(posedge clk) disable iff (rst)
        (run && !step && !clear) |=> (cnt == $past(cnt))); // R10

endmodule

// File: rtl/tmr_outreg.sv
module tmr_outreg
    import casc_tmr_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     toggle_en,
    input  tmr_evt_t evt,
    output logic     lo_match,
    output logic     lo_irq,
    output logic     period_irq,
    output logic     tmr_out
);

    always_ff @(posedge clk) begin
        if (rst) begin
            lo_match   <= 1'b0;
            lo_irq     <= 1'b0;
            period_irq <= 1'b0;
            tmr_out    <= 1'b0;
        end else begin
            lo_match   <= evt.lo_hit;
            lo_irq     <= evt.lo_hit;
            period_irq <= evt.coinc;
            if (evt.coinc && toggle_en) begin
                tmr_out <= ~tmr_out;
            end
        end
    end

    AST_IRQ_ON_COINC: assert property (@(posedge clk) disable iff (rst)
        evt.coinc |=> period_irq); // R4

    AST_OUT_FLIP: assert property (@(posedge clk) disable iff (rst)
        (evt.coinc && toggle_en) |=> (tmr_out != $past(tmr_out))); // R5

    AST_OUT_HOLD: assert property (@(posedge clk) disable iff (rst)
        !(evt.coinc && toggle_en) |=> $stable(tmr_out)); // R5

endmodule

// File: rtl/casc_cmp_timer.sv
module casc_cmp_timer
    import casc_tmr_pkg::*;
#(
    parameter int unsigned SEG_W = TMR_SEG_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick_en,
    input  logic             run,
    input  logic [SEG_W-1:0] cmp_lo,
    input  logic [SEG_W-1:0] cmp_hi,
    input  logic             toggle_en,
    output logic             lo_match,
    output logic             lo_irq,
    output logic             period_irq,
    output logic             tmr_out
);

    localparam int unsigned N_SEG = TMR_N_SEG;

    logic [SEG_W-1:0] cmp_arr [N_SEG];
    logic [SEG_W-1:0] cnt_arr [N_SEG];
    logic [N_SEG-1:0] eq_v;
    logic [N_SEG-1:0] hit_v;
    logic [N_SEG-1:0] step_v;
    logic             coinc;
    tmr_evt_t         evt;

    assign cmp_arr[0]         = cmp_lo;
    assign cmp_arr[N_SEG-1]   = cmp_hi;

    generate
        for (genvar g = 0; g < N_SEG; g++) begin : g_seg
            if (g == 0) begin : g_first
                assign step_v[g] = tick_en;
            end else begin : g_chain
                logic below_full;
                always_comb begin
                    below_full = 1'b1;
                    for (int k = 0; k < g; k++) begin
                        below_full = below_full & (&cnt_arr[k]);
                    end
                end
                assign step_v[g] = tick_en & below_full;
            end

            assign hit_v[g] = run & tick_en & eq_v[g];

            tmr_seg #(.W(SEG_W)) u_seg (
                .clk   (clk),
                .rst   (rst),
                .run   (run),
                .step  (step_v[g]),
                .clear (coinc),
                .cmp   (cmp_arr[g]),
                .cnt   (cnt_arr[g]),
                .eq    (eq_v[g])
            );
        end
    endgenerate

    assign coinc = &hit_v;
    assign evt   = tmr_make_evt(hit_v[0], coinc);

    tmr_outreg u_out (
        .clk        (clk),
        .rst        (rst),
        .toggle_en  (toggle_en),
        .evt        (evt),
        .lo_match   (lo_match),
        .lo_irq     (lo_irq),
        .period_irq (period_irq),
        .tmr_out    (tmr_out)
    );

    logic [SEG_W-1:0] cnt_lo_w;
    logic [SEG_W-1:0] cnt_hi_w;
    assign cnt_lo_w = cnt_arr[0];
    assign cnt_hi_w = cnt_arr[N_SEG-1];

    AST_LO_NO_CLEAR: assert property (@(posedge clk) disable iff (rst)
        (hit_v[0] && !coinc) |=> (cnt_lo_w == SEG_W'($past(cnt_lo_w) + SEG_W'(1)))); // R1

    AST_HI_ONLY_ON_WRAP: assert property (@(posedge clk) disable iff (rst)
        (run && !coinc && !(tick_en && (&cnt_lo_w))) |=> (cnt_hi_w == $past(cnt_hi_w))); // R2

    AST_COINC_CLEAR: assert property (@(posedge clk) disable iff (rst)
        coinc |=> (cnt_lo_w == '0 && cnt_hi_w == '0)); // R3

    AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (rst)
        !run |=> (cnt_lo_w == '0 && cnt_hi_w == '0 && !lo_match && !period_irq)); // R8

endmodule

// File: tb/test_casc_cmp_timer.sv
module test_casc_cmp_timer;

    logic       clk = 1'b0;
    logic       rst;
    logic       tick_en;
    logic       run;
    logic [7:0] cmp_lo;
    logic [7:0] cmp_hi;
    logic       toggle_en;
    logic       lo_match;
    logic       lo_irq;
    logic       period_irq;
    logic       tmr_out;

    int checks   = 0;
    int failures = 0;
    int cycles   = 0;
    bit done     = 1'b0;

    logic [15:0] m_cnt;
    logic        m_out;

    always #2.5 clk = ~clk;

    casc_cmp_timer i_casc_cmp_timer (
        .clk        (clk),
        .rst        (rst),
        .tick_en    (tick_en),
        .run        (run),
        .cmp_lo     (cmp_lo),
        .cmp_hi     (cmp_hi),
        .toggle_en  (toggle_en),
        .lo_match   (lo_match),
        .lo_irq     (lo_irq),
        .period_irq (period_irq),
        .tmr_out    (tmr_out)
    );

    function automatic logic f_lo_hit(input logic [15:0] c, input logic [7:0] cl, input logic t, input logic r);
        return r && t && (c[7:0] == cl);
    endfunction

    function automatic logic f_hi_hit(input logic [15:0] c, input logic [7:0] ch, input logic t, input logic r);
        return r && t && (c[15:8] == ch);
    endfunction

    task automatic chk(input logic act, input logic exp, input string tag);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0b expected=%0b at cycle %0d", tag, act, exp, cycles);
        end
    endtask

    // One counting step: drive at falling edge, one rising edge, sample at next falling edge.
    task automatic cyc(input logic t, input logic r, input logic g, input bit do_chk);
        logic e_lo, e_hi;
        tick_en   = t;
        run       = r;
        toggle_en = g;
        e_lo = f_lo_hit(m_cnt, cmp_lo, t, r);
        e_hi = f_hi_hit(m_cnt, cmp_hi, t, r);
        if (!r)                m_cnt = 16'h0;
        else if (e_lo && e_hi) m_cnt = 16'h0;
        else if (t)            m_cnt = m_cnt + 16'h1;
        if (e_lo && e_hi && g) m_out = ~m_out;
        @(posedge clk);
        @(negedge clk);
        if (do_chk) begin
            chk(lo_match,   e_lo,         "R1 lo_match");
            chk(lo_irq,     e_lo,         "R7 lo_irq");
            chk(period_irq, e_lo && e_hi, "R4 period_irq");
            chk(tmr_out,    m_out,        "R5 tmr_out");
        end
    endtask

    task automatic do_reset();
        rst = 1'b1;
        tick_en = 1'b0; run = 1'b0; toggle_en = 1'b0;
        @(posedge clk);
        @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        m_cnt = 16'h0;
        m_out = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000 && !done) begin
            failures++;
            $display("FAIL watchdog expired at cycle %0d", cycles);
            finish_run();
        end
    end

    initial begin
        int seed_dummy;
        int gap;
        seed_dummy = $urandom(32'd20240611);
        cmp_lo = 8'h00; cmp_hi = 8'h00;
        @(negedge clk);
        do_reset();

        // R9: reset state
        chk(lo_match,   1'b0, "R9 lo_match after reset");
        chk(lo_irq,     1'b0, "R9 lo_irq after reset");
        chk(period_irq, 1'b0, "R9 period_irq after reset");
        chk(tmr_out,    1'b0, "R9 tmr_out after reset");

        // R6: worked example, two full periods, counting from zero
        cmp_hi = 8'h04; cmp_lo = 8'h80;
        cyc(1'b0, 1'b0, 1'b1, 1'b1);
        for (int k = 0; k < 2 * 16'h0481; k++) begin
            int p;
            p = k % 16'h0481;
            cyc(1'b1, 1'b1, 1'b1, 1'b1);
            chk(lo_match,   (p[7:0] == 8'h80),   "R6 low match position");
            chk(period_irq, (p == 16'h0480),     "R6 period end position");
        end
        chk(tmr_out, 1'b0, "R5 two toggles restore level");

        // R5: toggle disabled keeps level through a period
        cmp_hi = 8'h00; cmp_lo = 8'h03;
        cyc(1'b0, 1'b0, 1'b0, 1'b1);
        for (int k = 0; k < 8; k++) cyc(1'b1, 1'b1, 1'b0, 1'b1);
        chk(tmr_out, 1'b0, "R5 hold with toggle_en low");
        for (int k = 0; k < 4; k++) cyc(1'b1, 1'b1, 1'b1, 1'b1);
        chk(tmr_out, 1'b1, "R5 flip with toggle_en high");

        // R2 and R3: high segment steps only on low wrap; period 0x111 steps
        cmp_hi = 8'h01; cmp_lo = 8'h10;
        cyc(1'b0, 1'b0, 1'b1, 1'b1);
        gap = 0;
        for (int k = 0; k < 16'h0111 * 2; k++) begin
            cyc(1'b1, 1'b1, 1'b1, 1'b1);
            gap++;
            if (period_irq) begin
                chk(gap == 16'h0111, 1'b1, "R2 R3 period length 0x111 steps");
                gap = 0;
            end
        end
        chk(gap == 0, 1'b1, "R3 second period closed");

        // R10: tick_en low while the low count sits on its compare value
        cmp_hi = 8'h00; cmp_lo = 8'h02;
        cyc(1'b0, 1'b0, 1'b1, 1'b1);
        cyc(1'b1, 1'b1, 1'b1, 1'b1);
        cyc(1'b1, 1'b1, 1'b1, 1'b1);
        for (int k = 0; k < 6; k++) begin
            cyc(1'b0, 1'b1, 1'b1, 1'b1);
            chk(lo_match | period_irq, 1'b0, "R10 no pulse while tick_en low");
        end
        cyc(1'b1, 1'b1, 1'b1, 1'b1);
        chk(period_irq, 1'b1, "R10 count held, match on next step");

        // R8: run low holds counts at zero and masks pulses
        cmp_hi = 8'h00; cmp_lo = 8'h05;
        cyc(1'b1, 1'b1, 1'b1, 1'b1);
        cyc(1'b1, 1'b1, 1'b1, 1'b1);
        for (int k = 0; k < 10; k++) begin
            cyc(1'b1, 1'b0, 1'b1, 1'b1);
            chk(lo_match | lo_irq | period_irq, 1'b0, "R8 pulses masked while idle");
        end
        for (int k = 0; k < 6; k++) begin
            cyc(1'b1, 1'b1, 1'b1, 1'b1);
            chk(period_irq, (k == 5), "R8 restart from zero");
        end

        // Constrained random phase
        for (int k = 0; k < 4000; k++) begin
            logic t, r, g;
            if (k % 250 == 0) begin
                cmp_hi = 8'($urandom_range(0, 1));
                cmp_lo = 8'($urandom_range(0, 255));
            end
            t = ($urandom_range(0, 3) != 0);
            r = ($urandom_range(0, 31) != 0);
            g = ($urandom_range(0, 3) != 0);
            cyc(t, r, g, 1'b1);
        end

        // R9: reset in mid-count returns everything to zero
        cmp_hi = 8'h00; cmp_lo = 8'h01;
        cyc(1'b1, 1'b1, 1'b1, 1'b1);
        do_reset();
        chk(tmr_out | lo_match | period_irq, 1'b0, "R9 mid-run reset clears outputs");
        for (int k = 0; k < 2; k++) begin
            cyc(1'b1, 1'b1, 1'b1, 1'b1);
            chk(period_irq, (k == 1), "R9 counts restart at zero");
        end

        finish_run();
    end

endmodule